// File: doc/BRIEF.md
# Row/Column Striped Static Memory

This block is a single-port static memory. Its address is split in two fields. The upper field goes to a row decoder, which raises exactly one word line. That word line is shared by a set of narrow bit banks, with one bank for each bit of the data word. The lower field drives a column multiplexer inside every bank, and each multiplexer picks one cell out of the active row. A stored word is therefore spread across all banks, with bit i held by bank i at the addressed row and column. Compared with a flat array, the row decoder is smaller and each output multiplexer is narrower.

Three active-high controls govern an access: select, output enable and write enable. Reads are combinational from the address. Writes take effect on the rising clock edge. Because there is only one port, a selected cycle with write enable high writes and does not present data. When the block is not presenting data, the output is held at zero and a high-impedance flag is raised in place of a real three-state bus. `ROW_BITS`, `COL_BITS` and `WIDTH` set the geometry. The defaults give a 16-word by 4-bit memory.

Top module: `rowcol_sram`

## Requirements
- R1: Address bits [ROW_BITS+COL_BITS-1:COL_BITS] select the row and bits [COL_BITS-1:0] select the column. Every one of the 2^(ROW_BITS+COL_BITS) addresses holds its own independent WIDTH-bit word, and exactly one word line is active at any time.
- R2: When `sel` and `wr` are both 1 at a rising clock edge, the word at `addr` becomes `wdata`. No other address changes, including those sharing the same row or the same column.
- R3: A rising edge with `sel`=0 or `wr`=0 leaves every stored word unchanged.
- R4: While `sel`=1, `oe`=1 and `wr`=0, `rdata` equals the word stored at the current `addr` in the same cycle, with no clock edge in between.
- R5: `drive` is 1 exactly when `sel`=1, `oe`=1 and `wr`=0. A write cycle therefore never presents data.
- R6: While `drive`=0, `rdata` is all zeros and `hiz` is 1. While `drive`=1, `hiz` is 0.
- R7: While `rst_n`=0, every stored word is cleared to zero. After reset, every address reads back zero until it is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes land on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset that clears the array |
| sel | input | 1 | Chip select, active high |
| oe | input | 1 | Output enable, active high |
| wr | input | 1 | Write enable, active high |
| addr | input | ROW_BITS+COL_BITS | Word address (row field high, column field low) |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, zero when not driving |
| drive | output | 1 | Output is presenting data |
| hiz | output | 1 | Output would be undriven |

## Verification
The bench builds the block with its defaults: 2 row bits, 2 column bits and a 4-bit word, which gives 16 addresses. At that size every address can be swept after each phase. A sweep shows whether a write has disturbed a neighbour in the same row or the same column, and whether an ignored write has left a trace. A long run of random mixed accesses is then compared against a flat reference memory, and it covers every combination of the three controls.

// File: rtl/rcs_pkg.sv
package rcs_pkg;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } access_e;

   function automatic access_e classify(input logic sel, input logic oe, input logic wr);
      if (!sel)     return ACC_IDLE;
      else if (wr)  return ACC_WRITE;
      else if (oe)  return ACC_READ;
      else          return ACC_IDLE;
   endfunction

endpackage

// File: rtl/rcs_row_decoder.sv
module rcs_row_decoder #(
   parameter int ROW_BITS = 2
) (
   input  logic [ROW_BITS-1:0]      row,
   output logic [(1<<ROW_BITS)-1:0] word_line
);
   localparam int ROWS = 1 << ROW_BITS;

   for (genvar r = 0; r < ROWS; r++) begin : g_line
      assign word_line[r] = (row == ROW_BITS'(r));
   end

endmodule

// File: rtl/rcs_col_mux.sv
module rcs_col_mux #(
   parameter int COL_BITS = 2
) (
   input  logic [(1<<COL_BITS)-1:0] line,
   input  logic [COL_BITS-1:0]      col,
   output logic                     bit_out
);
   if (COL_BITS < 1) begin : g_bad
      $error("rcs_col_mux: COL_BITS must be at least 1");
   end else if (COL_BITS == 1) begin : g_two
      assign bit_out = col[0] ? line[1] : line[0];
   end else begin : g_wide
      assign bit_out = line[col];
   end

endmodule

// File: rtl/rcs_bit_bank.sv
module rcs_bit_bank #(
   parameter int ROW_BITS = 2,
   parameter int COL_BITS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [(1<<ROW_BITS)-1:0] word_line,
   input  logic [COL_BITS-1:0]      col_sel,
   input  logic                     wr_strobe,
   input  logic                     bit_in,
   output logic                     bit_out
);
   localparam int ROWS = 1 << ROW_BITS;
   localparam int COLS = 1 << COL_BITS;

   logic [ROWS-1:0][COLS-1:0] cells;
   logic [COLS-1:0]           line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else if (wr_strobe) begin
         for (int r = 0; r < ROWS; r++) begin
            if (word_line[r]) cells[r][col_sel] <= bit_in;
         end
      end
   end

   // shared bit lines: the active row is OR-ed onto the column lines
   always_comb begin
      line = '0;
      for (int r = 0; r < ROWS; r++) begin
         line |= cells[r] & {COLS{word_line[r]}};
      end
   end

   rcs_col_mux #(.COL_BITS(COL_BITS)) u_mux (
      .line    (line),
      .col     (col_sel),
      .bit_out (bit_out)
   );

   for (genvar r = 0; r < ROWS; r++) begin : g_chk
      AST_CELL_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_strobe && word_line[r]) |=> cells[r][$past(col_sel)] == $past(bit_in)); // R2
   end

   AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_strobe |=> $stable(cells)); // R3

endmodule

// File: rtl/rowcol_sram.sv
module rowcol_sram
   import rcs_pkg::*;
#(
   parameter int ROW_BITS = 2,
   parameter int COL_BITS = 2,
   parameter int WIDTH    = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         sel,
   input  logic                         oe,
   input  logic                         wr,
   input  logic [ROW_BITS+COL_BITS-1:0] addr,
   input  logic [WIDTH-1:0]             wdata,
   output logic [WIDTH-1:0]             rdata,
   output logic                         drive,
   output logic                         hiz
);
   localparam int AW   = ROW_BITS + COL_BITS;
   localparam int ROWS = 1 << ROW_BITS;

   if (ROW_BITS < 1 || COL_BITS < 1 || WIDTH < 1) begin : g_param_bad
      $error("rowcol_sram: ROW_BITS, COL_BITS and WIDTH must each be at least 1");
   end
   if (AW > 24) begin : g_param_big
      $error("rowcol_sram: address wider than 24 bits is not supported");
   end

   logic [ROW_BITS-1:0] row_sel;
   logic [COL_BITS-1:0] col_sel;
   logic [ROWS-1:0]     word_line;
   logic [WIDTH-1:0]    bank_bits;
   access_e             access;
   logic                wr_strobe;

   assign row_sel   = addr[AW-1:COL_BITS];
   assign col_sel   = addr[COL_BITS-1:0];
   assign access    = classify(sel, oe, wr);
   assign wr_strobe = (access == ACC_WRITE);
   assign drive     = (access == ACC_READ);
   assign hiz       = ~drive;

   rcs_row_decoder #(.ROW_BITS(ROW_BITS)) u_rowdec (
      .row       (row_sel),
      .word_line (word_line)
   );

   AST_ONE_WORD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(word_line)); // R1

   for (genvar i = 0; i < WIDTH; i++) begin : g_bank
      rcs_bit_bank #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) u_bank (
         .clk       (clk),
         .rst_n     (rst_n),
         .word_line (word_line),
         .col_sel   (col_sel),
         .wr_strobe (wr_strobe),
         .bit_in    (wdata[i]),
         .bit_out   (bank_bits[i])
      );
   end

   assign rdata = drive ? bank_bits : '0;

   AST_QUIET_WHEN_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      hiz |-> (rdata == '0)); // R6

   AST_NO_DATA_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      wr |-> !drive); // R5

endmodule

// File: tb/sim_rowcol_sram.sv
module sim_rowcol_sram;
   localparam int ROW_BITS = 2;
   localparam int COL_BITS = 2;
   localparam int WIDTH    = 4;
   localparam int AW       = ROW_BITS + COL_BITS;
   localparam int DEPTH    = 1 << AW;

   typedef struct {
      logic [WIDTH-1:0] data;
      logic             drv;
      logic             hz;
      string            tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel = 1'b0, oe = 1'b0, wr = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [WIDTH-1:0] wdata = '0;
   logic [WIDTH-1:0] rdata;
   logic             drive, hiz;

   logic [WIDTH-1:0] ref_mem [DEPTH];
   exp_t             sb [$];
   int               checks = 0;
   int               errors = 0;
   bit               done = 1'b0;

   always #10 clk = ~clk;

   rowcol_sram #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .WIDTH(WIDTH)) u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .oe(oe), .wr(wr),
      .addr(addr), .wdata(wdata), .rdata(rdata), .drive(drive), .hiz(hiz)
   );

   task automatic access(input logic s, input logic o, input logic w,
                         input logic [AW-1:0] a, input logic [WIDTH-1:0] d,
                         input string tag);
      exp_t e;
      @(posedge clk);
      #1;
      sel = s; oe = o; wr = w; addr = a; wdata = d;
      e.drv  = s & o & ~w;
      e.hz   = ~e.drv;
      e.data = e.drv ? ref_mem[a] : '0;
      e.tag  = tag;
      sb.push_back(e);
      if (s && w) ref_mem[a] = d;
   endtask

   task automatic sweep(input string tag);
      for (int a = 0; a < DEPTH; a++) access(1'b1, 1'b1, 1'b0, AW'(a), '0, tag);
   endtask

   // monitor: compares once per cycle, away from the rising edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         checks++;
         if (rdata !== e.data || drive !== e.drv || hiz !== e.hz) begin
            errors++;
            $display("FAIL %s: addr=%0d rdata=%h drive=%b hiz=%b expected rdata=%h drive=%b hiz=%b",
                     e.tag, addr, rdata, drive, hiz, e.data, e.drv, e.hz);
         end
      end
   end

   initial begin
      for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      access(1'b0, 1'b1, 1'b0, '0, '0, "R6");        // deselected after reset
      sweep("R7");                                     // array cleared

      for (int a = 0; a < DEPTH; a++)
         access(1'b1, 1'b1, 1'b1, AW'(a), WIDTH'(a * 5 + 3), "R5");
      sweep("R1");

      access(1'b1, 1'b0, 1'b0, AW'(6), '0, "R6");     // output disabled
      access(1'b0, 1'b1, 1'b0, AW'(6), '0, "R6");     // not selected
      access(1'b1, 1'b1, 1'b0, AW'(6), '0, "R4");

      access(1'b0, 1'b1, 1'b1, AW'(5), 4'hA, "R3");   // write without select
      access(1'b1, 1'b1, 1'b0, AW'(5), '0, "R3");
      access(1'b1, 1'b0, 1'b0, AW'(9), 4'h6, "R3");   // select without write
      access(1'b1, 1'b1, 1'b0, AW'(9), '0, "R3");

      access(1'b1, 1'b0, 1'b1, AW'(10), 4'hF, "R2");  // row 2, col 2
      access(1'b1, 1'b1, 1'b1, AW'(10), 4'h0, "R2");  // overwrite
      access(1'b1, 1'b0, 1'b1, AW'(10), 4'h9, "R2");
      sweep("R2");                                     // neighbours untouched

      for (int n = 0; n < 600; n++) begin
         logic [2:0] c;
         c = 3'($urandom);
         access(c[0], c[1], c[2], AW'($urandom), WIDTH'($urandom), "R4");
      end
      sweep("R1");

      access(1'b0, 1'b0, 1'b0, '0, '0, "R6");
      @(posedge clk);
      while (sb.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule